// File: doc/BRIEF.md
# Nonvolatile Array Program and Erase Controller

This block owns a word-addressed nonvolatile storage model: a main array split into a parameterised number of equal pages, and a small separate region that holds user configuration words. Software-visible behaviour is set through a handful of control selectors. A two-bit mode field decides whether array writes are accepted, whether erase requests are accepted, or neither. Erased words read as all ones. Programming can only clear bits, because each write is ANDed into the word that is already stored.

Erasing works at three scopes. A single page is erased through either of two page-erase selectors, which behave the same. Both take a word address and round it down to its page. The whole main array can be erased at once, and so can the user region on its own. A status selector always reports the controller as ready, since every operation finishes in a single clock edge.

Top module: `flash_ctrl`

## Requirements
- R1: After reset the mode field is 0 and every word of both the main array and the user region reads 0xFFFFFFFF.
- R2: Control selector 0 holds the mode in bits [1:0]. Any written value, including 3, reads back in those bits, and bits [31:2] read 0. Codes: 0 = locked, 1 = program, 2 = erase, 3 = neither.
- R3: Control selector 1 (status) always reads 0x00000001.
- R4: In mode 1, an array write stores old AND new into the addressed word. The main array takes word index arr_waddr. The user region (arr_user=1) takes the low log2(USER_WORDS) address bits. The result is readable on the cycle after the write edge.
- R5: In modes 0, 2 and 3, array writes leave both regions unchanged.
- R6: In mode 2, a control write to selector 2 or to selector 3 takes bits [AW-1:0] of the data as a word index. It clears that index down to a PAGE_WORDS boundary and sets every word of that page to 0xFFFFFFFF.
- R7: In mode 2, writing exactly 0x00000001 to selector 4 sets every word of the main array to 0xFFFFFFFF and leaves the user region unchanged.
- R8: In mode 2, writing exactly 0x00000001 to selector 5 sets every user-region word to 0xFFFFFFFF and leaves the main array unchanged.
- R9: Erase selectors have no effect outside mode 2. Selectors 4 and 5 also have no effect for any data value other than 0x00000001.
- R10: A page erase leaves every word outside the selected page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control write strobe |
| reg_waddr | input | 3 | Control write selector |
| reg_wdata | input | 32 | Control write data |
| reg_raddr | input | 3 | Control read selector |
| reg_rdata | output | 32 | Control read data (combinational) |
| arr_we | input | 1 | Array write strobe |
| arr_user | input | 1 | Array write targets the user region |
| arr_waddr | input | AW | Array write word index |
| arr_wdata | input | 32 | Array write data |
| arr_rdsel_user | input | 1 | Array read from the user region |
| arr_raddr | input | AW | Array read word index |
| arr_rdata | output | 32 | Array read data (combinational) |

## Verification
A mode change, a program or any erase is applied on the clock edge that samples its strobe. Both read ports are combinational, so each result is due one cycle after the stimulus edge. The bench changes inputs just after a rising edge, and its reference model applies the same operation on the next rising edge. Every falling edge compares both read ports against the model, so each result is checked at the first point it can legally appear. It is checked again on every later cycle until something overwrites it.

// File: rtl/fctl_pkg.sv
package fctl_pkg;
  typedef enum logic [1:0] {
    MODE_LOCKED = 2'd0,
    MODE_PROG   = 2'd1,
    MODE_ERASE  = 2'd2,
    MODE_SPARE  = 2'd3
  } fmode_e;

  localparam logic [2:0] SEL_MODE      = 3'd0;
  localparam logic [2:0] SEL_STATUS    = 3'd1;
  localparam logic [2:0] SEL_PGERA     = 3'd2;
  localparam logic [2:0] SEL_PGERB     = 3'd3;
  localparam logic [2:0] SEL_WIPE_MAIN = 3'd4;
  localparam logic [2:0] SEL_WIPE_USER = 3'd5;

  localparam logic [31:0] ERASED_WORD = 32'hFFFF_FFFF;
  localparam logic [31:0] TRIGGER_VAL = 32'h0000_0001;

  // Programming can only pull bits low.
  function automatic logic [31:0] program_word(input logic [31:0] old_w,
                                               input logic [31:0] new_w);
    return old_w & new_w;
  endfunction
endpackage

// File: rtl/fctl_cfg.sv
module fctl_cfg
  import fctl_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_waddr,
  input  logic [31:0]   reg_wdata,
  input  logic [2:0]    reg_raddr,
  output logic [31:0]   reg_rdata,
  output logic          prog_ok,
  output logic          erase_ok,
  output logic          pg_erase,
  output logic [AW-1:0] pg_word,
  output logic          wipe_main,
  output logic          wipe_user
);
  fmode_e mode_q;
  logic   trig_one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_LOCKED;
    else if (reg_we && reg_waddr == SEL_MODE) mode_q <= fmode_e'(reg_wdata[1:0]);
  end

  assign trig_one  = (reg_wdata == TRIGGER_VAL);
  assign prog_ok   = (mode_q == MODE_PROG);
  assign erase_ok  = (mode_q == MODE_ERASE);
  assign pg_erase  = reg_we && erase_ok &&
                     (reg_waddr == SEL_PGERA || reg_waddr == SEL_PGERB);
  assign pg_word   = reg_wdata[AW-1:0];
  assign wipe_main = reg_we && erase_ok && trig_one && (reg_waddr == SEL_WIPE_MAIN);
  assign wipe_user = reg_we && erase_ok && trig_one && (reg_waddr == SEL_WIPE_USER);

  always_comb begin
    case (reg_raddr)
      SEL_MODE:   reg_rdata = {30'd0, mode_q};
      SEL_STATUS: reg_rdata = 32'd1;
      default:    reg_rdata = 32'd0;
    endcase
  end

  assert_mode_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_waddr == SEL_MODE) |=> (mode_q == fmode_e'($past(reg_wdata[1:0]))));

  assert_mode_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_raddr == SEL_MODE) |-> (reg_rdata[31:2] == 30'd0));

  assert_erase_needs_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_erase || wipe_main || wipe_user) |-> (mode_q == MODE_ERASE));
endmodule

// File: rtl/fctl_bank.sv
module fctl_bank
  import fctl_pkg::*;
#(
  parameter int WORDS      = 1024,
  parameter int PAGE_WORDS = 4,
  localparam int IW        = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic          pg_erase,
  input  logic [IW-1:0] pg_idx,
  input  logic          all_erase,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_data
);
  logic [31:0]   mem [WORDS];
  logic [IW-1:0] pg_base;

  function automatic logic [IW-1:0] page_floor(input logic [IW-1:0] a);
    return a & ~IW'(PAGE_WORDS - 1);
  endfunction

  assign pg_base = page_floor(pg_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= ERASED_WORD;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (all_erase || (pg_erase && page_floor(IW'(i)) == pg_base))
          mem[i] <= ERASED_WORD;
        else if (wr_en && wr_idx == IW'(i))
          mem[i] <= program_word(mem[i], wr_data);
      end
    end
  end

  assign rd_data = mem[rd_idx];

  assert_prog_clears_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pg_erase && !all_erase) |=> ((mem[$past(wr_idx)] & ~$past(wr_data)) == 32'd0));

  assert_page_first_erased_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_erase && !wr_en) |=> (mem[$past(pg_base)] == ERASED_WORD));

  assert_page_last_erased_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_erase && !wr_en) |=> (mem[$past(pg_base) + IW'(PAGE_WORDS - 1)] == ERASED_WORD));

  assert_wipe_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    all_erase |=> (mem[0] == ERASED_WORD && mem[WORDS-1] == ERASED_WORD));
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import fctl_pkg::*;
#(
  parameter int PAGES      = 256,
  parameter int PAGE_WORDS = 4,
  parameter int USER_WORDS = 16,
  localparam int MAIN_WORDS = PAGES * PAGE_WORDS,
  localparam int AW         = $clog2(MAIN_WORDS),
  localparam int UAW        = $clog2(USER_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_waddr,
  input  logic [31:0]   reg_wdata,
  input  logic [2:0]    reg_raddr,
  output logic [31:0]   reg_rdata,
  input  logic          arr_we,
  input  logic          arr_user,
  input  logic [AW-1:0] arr_waddr,
  input  logic [31:0]   arr_wdata,
  input  logic          arr_rdsel_user,
  input  logic [AW-1:0] arr_raddr,
  output logic [31:0]   arr_rdata
);
  logic          prog_ok, erase_ok, pg_erase, wipe_main, wipe_user;
  logic [AW-1:0] pg_word;
  logic          main_wr, user_wr;
  logic [31:0]   main_rd, user_rd;

  fctl_cfg #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .prog_ok(prog_ok), .erase_ok(erase_ok),
    .pg_erase(pg_erase), .pg_word(pg_word),
    .wipe_main(wipe_main), .wipe_user(wipe_user)
  );

  assign main_wr = arr_we && !arr_user && prog_ok;
  assign user_wr = arr_we &&  arr_user && prog_ok;

  fctl_bank #(.WORDS(MAIN_WORDS), .PAGE_WORDS(PAGE_WORDS)) u_main (
    .clk(clk), .rst_n(rst_n),
    .wr_en(main_wr), .wr_idx(arr_waddr), .wr_data(arr_wdata),
    .pg_erase(pg_erase), .pg_idx(pg_word), .all_erase(wipe_main),
    .rd_idx(arr_raddr), .rd_data(main_rd)
  );

  fctl_bank #(.WORDS(USER_WORDS), .PAGE_WORDS(USER_WORDS)) u_user (
    .clk(clk), .rst_n(rst_n),
    .wr_en(user_wr), .wr_idx(arr_waddr[UAW-1:0]), .wr_data(arr_wdata),
    .pg_erase(1'b0), .pg_idx('0), .all_erase(wipe_user),
    .rd_idx(arr_raddr[UAW-1:0]), .rd_data(user_rd)
  );

  assign arr_rdata = arr_rdsel_user ? user_rd : main_rd;

  assert_write_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (main_wr || user_wr) |-> (prog_ok && !erase_ok));

  assert_user_wipe_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe_user && !arr_rdsel_user) |=>
      (!$stable(arr_raddr) || arr_rdsel_user || $stable(arr_rdata)));
endmodule

// File: tb/tb_flash_ctrl.sv
`timescale 1ns/1ps
module tb_flash_ctrl;
  localparam int PAGES = 256, PW = 4, UW = 16;
  localparam int NW = PAGES * PW;
  localparam int AW = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_waddr = '0, reg_raddr = '0;
  logic [31:0]   reg_wdata = '0, reg_rdata;
  logic          arr_we = 1'b0, arr_user = 1'b0, arr_rdsel_user = 1'b0;
  logic [AW-1:0] arr_waddr = '0, arr_raddr = '0;
  logic [31:0]   arr_wdata = '0, arr_rdata;

  flash_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .arr_we(arr_we), .arr_user(arr_user), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .arr_rdsel_user(arr_rdsel_user), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata)
  );

  // Behavioural reference model
  logic [31:0] m_main [NW];
  logic [31:0] m_user [UW];
  int          m_mode;
  string       cur_req = "R1";
  int          n_tests = 0, n_fail = 0;
  bit          done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) m_main[i] = 32'hFFFFFFFF;
      for (int i = 0; i < UW; i++) m_user[i] = 32'hFFFFFFFF;
      m_mode = 0;
    end else begin
      if (arr_we && m_mode == 1) begin
        if (arr_user) m_user[int'(arr_waddr) % UW] = m_user[int'(arr_waddr) % UW] & arr_wdata;
        else          m_main[int'(arr_waddr)] = m_main[int'(arr_waddr)] & arr_wdata;
      end
      if (reg_we) begin
        if ((reg_waddr == 2 || reg_waddr == 3) && m_mode == 2) begin
          int base;
          base = ((int'(reg_wdata) % NW) / PW) * PW;
          for (int k = 0; k < PW; k++) m_main[base + k] = 32'hFFFFFFFF;
        end
        if (reg_waddr == 4 && m_mode == 2 && reg_wdata == 1)
          for (int i = 0; i < NW; i++) m_main[i] = 32'hFFFFFFFF;
        if (reg_waddr == 5 && m_mode == 2 && reg_wdata == 1)
          for (int i = 0; i < UW; i++) m_user[i] = 32'hFFFFFFFF;
        if (reg_waddr == 0) m_mode = int'(reg_wdata[1:0]);
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] exp_a, exp_r;
      exp_a = arr_rdsel_user ? m_user[int'(arr_raddr) % UW] : m_main[int'(arr_raddr)];
      case (reg_raddr)
        3'd0:    exp_r = 32'(m_mode);
        3'd1:    exp_r = 32'd1;
        default: exp_r = 32'd0;
      endcase
      n_tests += 2;
      if (arr_rdata !== exp_a) begin
        n_fail++;
        $display("FAIL %s array user=%0d idx=%0d actual=%h expected=%h",
                 cur_req, arr_rdsel_user, arr_raddr, arr_rdata, exp_a);
      end
      if (reg_rdata !== exp_r) begin
        n_fail++;
        $display("FAIL %s control sel=%0d actual=%h expected=%h",
                 cur_req, reg_raddr, reg_rdata, exp_r);
      end
    end
  end

  task automatic ctl_wr(input int sel, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_waddr = 3'(sel); reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic arr_wr(input bit usr, input int idx, input logic [31:0] d);
    @(posedge clk); #1;
    arr_we = 1'b1; arr_user = usr; arr_waddr = AW'(idx); arr_wdata = d;
    @(posedge clk); #1;
    arr_we = 1'b0;
  endtask

  task automatic look(input bit usr, input int idx, input int sel);
    @(posedge clk); #1;
    arr_rdsel_user = usr; arr_raddr = AW'(idx); reg_raddr = 3'(sel);
    @(posedge clk);
  endtask

  task automatic sweep(input bit usr);
    for (int i = 0; i < (usr ? UW : NW); i++) begin
      @(posedge clk); #1;
      arr_rdsel_user = usr; arr_raddr = AW'(i);
    end
    @(posedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog all requirements actual=hung expected=complete");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    cur_req = "R1";   sweep(0); sweep(1); look(0, 0, 0);
    cur_req = "R3";   look(0, 0, 1); look(0, 0, 6);

    cur_req = "R2";   ctl_wr(0, 32'd3); look(0, 0, 0);
    ctl_wr(0, 32'hFFFF_FFFE); look(0, 0, 0);
    ctl_wr(0, 32'd0); look(0, 0, 0);
    cur_req = "R3";   look(0, 0, 1);

    cur_req = "R4";   ctl_wr(0, 32'd1);
    arr_wr(0, 5, 32'h1234_ABCD); look(0, 5, 0);
    arr_wr(0, 5, 32'hFFFF_00FF); look(0, 5, 0);
    arr_wr(1, 3, 32'hA5A5_A5A5); look(1, 3, 0);
    arr_wr(0, NW-1, 32'h0); look(0, NW-1, 0);
    arr_wr(0, 6, 32'h5555_0000); look(0, 6, 0);

    cur_req = "R5";
    ctl_wr(0, 32'd0); arr_wr(0, 6, 32'h0); look(0, 6, 0);
    ctl_wr(0, 32'd2); arr_wr(0, 6, 32'h0); look(0, 6, 0);
    ctl_wr(0, 32'd3); arr_wr(1, 3, 32'h0); look(1, 3, 0); look(0, 6, 0);

    cur_req = "R9";
    ctl_wr(0, 32'd0); ctl_wr(2, 32'd5); look(0, 5, 0);
    ctl_wr(0, 32'd1); ctl_wr(3, 32'd5); ctl_wr(4, 32'd1); ctl_wr(5, 32'd1);
    look(0, 5, 0); look(1, 3, 0);
    ctl_wr(0, 32'd2); ctl_wr(4, 32'd0); ctl_wr(4, 32'h8000_0001); ctl_wr(5, 32'd3);
    look(0, 5, 0); look(0, NW-1, 0); look(1, 3, 0);

    cur_req = "R6";
    ctl_wr(0, 32'd1);
    for (int i = 3; i <= 8; i++) arr_wr(0, i, 32'(i * 32'h0101_0101));
    ctl_wr(0, 32'd2); ctl_wr(2, 32'd6);
    for (int i = 3; i <= 8; i++) look(0, i, 0);
    cur_req = "R10";  look(0, 3, 0); look(0, 8, 0);
    cur_req = "R6";
    ctl_wr(0, 32'd1); arr_wr(0, NW-4, 32'h0); arr_wr(0, NW-5, 32'h0);
    ctl_wr(0, 32'd2); ctl_wr(3, 32'h0000_FC00 | 32'(NW-2));
    look(0, NW-4, 0); look(0, NW-1, 0);
    cur_req = "R10";  look(0, NW-5, 0);

    cur_req = "R8";
    ctl_wr(0, 32'd1); arr_wr(0, 9, 32'h0F0F_0F0F); arr_wr(1, UW-1, 32'h0);
    ctl_wr(0, 32'd2); look(0, 9, 0); ctl_wr(5, 32'd1);
    sweep(1); look(0, 9, 0);

    cur_req = "R7";
    ctl_wr(0, 32'd1); arr_wr(1, 2, 32'h1111_2222); arr_wr(0, 100, 32'h0);
    ctl_wr(0, 32'd2); look(0, 100, 0); ctl_wr(4, 32'd1);
    sweep(0); look(1, 2, 0); look(0, 100, 0);

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule